// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

This block is a bank of independent pulse-width modulated outputs. Each channel divides the input clock into time quanta with a prescaler whose ratio is 32 minus a 4-bit frequency code. A period is a fixed 1024 quanta. The output goes high at the start of each period and stays high for a programmed number of quanta, then stays low for the rest of the period. All configuration passes through a byte-wide synchronous register port: an address, write data, a write strobe and a combinational read-data bus.

Each channel has two byte registers and a bit in a shared enable register. A stored duty value D gives a high time of D+1 quanta. Duty and frequency writes go into shadow registers. A channel copies them into its working copy only when it starts a period, so a running period is never cut short or stretched. Each channel is a two-state machine. In `CH_IDLE` the output is low and the counters are cleared. Transition START (the enable bit is seen set) enters `CH_RUN` at quantum 0 and loads the shadows. In `CH_RUN`, transition WRAP (the last prescale cycle of quantum 1023) stays in `CH_RUN`, restarts at quantum 0 and reloads the shadows. Transition STOP (the enable bit is seen clear) returns to `CH_IDLE`.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0x00 and every PWM output is low.
- R2: With NUM_CH channels, channel n uses two registers. The register at address 2n holds stored duty bits [7:0]. The register at address 2n+1 holds stored duty bits [9:8] in bits [1:0] and the 4-bit frequency code in bits [7:4]. The enable register sits at address 2·NUM_CH, and its bit n enables channel n. Every written value reads back.
- R3: Bits [3:2] of each address-2n+1 register, and enable-register bits at or above NUM_CH, read as zero and ignore writes.
- R4: One quantum lasts 32 − F clock cycles, where F is the channel's frequency code.
- R5: A period lasts exactly 1024 quanta for every frequency code.
- R6: With stored duty D, the output is high for the first (D+1) quanta of each period and low for the rest. D = 0 gives a single quantum.
- R7: A stored duty of 1023 keeps the output high through every period boundary, with no low cycle.
- R8: A channel whose enable bit is clear drives its output low from the first cycle after the clearing write. Channels never affect one another.
- R9: Setting an enable bit starts a new period at quantum 0. The output rises in the second clock cycle after the enabling write's edge and uses the shadow values current at that moment.
- R10: Duty or frequency writes to a running channel leave the current period unchanged. They take effect from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address, ADDR_W = clog2(2·NUM_CH+1) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, takes effect on the clock edge |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Internal state in this block shows up only as edge positions on the outputs. A prescaler that runs one cycle long or short, or a quantum counter that wraps at the wrong place, moves the falling edge by (D+1) cycles. It also moves the next rising edge by up to 1024 cycles. The bench therefore compares every output level in every cycle against a period model over more than one period. A shadow copy that updates too early corrupts the period that is already running. That error appears within a few thousand cycles of the write, long before the boundary where the new values should apply. A restart that fails to clear the quantum counter shifts the first rising edge right after enable.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DUTY_W     = 10;
    localparam int FREQ_W     = 4;
    localparam int PRE_W      = 6;
    localparam int RATIO_BASE = 32;
    localparam int REG_W      = 8;

    localparam logic [DUTY_W-1:0] DUTY_LAST = '1;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pwm_bank_tick.sv
module pwm_bank_tick
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [FREQ_W-1:0] code,
    output logic [PRE_W-1:0]  count,
    output logic              tick
);

    logic [PRE_W-1:0] last;

    // ratio is RATIO_BASE - code, so the final count value is one less
    always_comb last = PRE_W'(RATIO_BASE - 1) - PRE_W'(code);
    always_comb tick = !hold && (count == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (hold || (count == last)) begin
            count <= '0;
        end else begin
            count <= count + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_sh_i,
    input  logic [FREQ_W-1:0] freq_sh_i,
    output logic              pwm_o,
    output logic              run_o,
    output logic              wrap_o,
    output logic [DUTY_W-1:0] quant_o,
    output logic [DUTY_W-1:0] duty_act_o,
    output logic [FREQ_W-1:0] freq_act_o,
    output logic [PRE_W-1:0]  pre_o
);

    ch_state_e         state_q, state_d;
    logic [DUTY_W-1:0] quant_q;
    logic [DUTY_W-1:0] duty_act_q;
    logic [FREQ_W-1:0] freq_act_q;
    logic              tick;
    logic [PRE_W-1:0]  pre_cnt;

    pwm_bank_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state_q != CH_RUN),
        .code  (freq_act_q),
        .count (pre_cnt),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, STOP, WRAP (self loop in CH_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: state_d = en_i ? CH_RUN : CH_IDLE;
            CH_RUN:  state_d = en_i ? CH_RUN : CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // quantum counter and working copies of the shadow values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quant_q    <= '0;
            duty_act_q <= '0;
            freq_act_q <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (en_i) begin
                        quant_q    <= '0;
                        duty_act_q <= duty_sh_i;
                        freq_act_q <= freq_sh_i;
                    end
                end
                CH_RUN: begin
                    if (tick) begin
                        if (quant_q == DUTY_LAST) begin
                            quant_q    <= '0;
                            duty_act_q <= duty_sh_i;
                            freq_act_q <= freq_sh_i;
                        end else begin
                            quant_q <= quant_q + DUTY_W'(1);
                        end
                    end
                end
                default: quant_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        run_o      = (state_q == CH_RUN);
        pwm_o      = en_i && run_o && (quant_q <= duty_act_q);
        wrap_o     = run_o && tick && (quant_q == DUTY_LAST);
        quant_o    = quant_q;
        duty_act_o = duty_act_q;
        freq_act_o = freq_act_q;
        pre_o      = pre_cnt;
    end

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [REG_W-1:0]                  wdata,
    input  logic                              we,
    output logic [REG_W-1:0]                  rdata,
    output logic [NUM_CH-1:0][DUTY_W-1:0]     duty_o,
    output logic [NUM_CH-1:0][FREQ_W-1:0]     freq_o,
    output logic [NUM_CH-1:0]                 en_o
);

    localparam int EN_ADDR = 2 * NUM_CH;
    localparam int HI_W    = DUTY_W - 8;

    logic [NUM_CH-1:0] en_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [DUTY_W-1:0] duty_q;
        logic [FREQ_W-1:0] freq_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_q <= '0;
                freq_q <= '0;
            end else if (we && (addr == ADDR_W'(2 * n))) begin
                duty_q[7:0] <= wdata;
            end else if (we && (addr == ADDR_W'(2 * n + 1))) begin
                duty_q[DUTY_W-1:8] <= wdata[HI_W-1:0];
                freq_q             <= wdata[REG_W-1:REG_W-FREQ_W];
            end
        end

        assign duty_o[n] = duty_q;
        assign freq_o[n] = freq_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we && (addr == ADDR_W'(EN_ADDR))) begin
            en_q <= wdata[NUM_CH-1:0];
        end
    end

    assign en_o = en_q;

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(2 * n)) begin
                rdata = duty_o[n][7:0];
            end else if (addr == ADDR_W'(2 * n + 1)) begin
                rdata = {freq_o[n], 2'b00, duty_o[n][DUTY_W-1:8]};
            end
        end
        if (addr == ADDR_W'(EN_ADDR)) begin
            rdata = REG_W'(en_q);
        end
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int ADDR_W = $clog2(2 * NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH-1:0][DUTY_W-1:0] duty_sh;
    logic [NUM_CH-1:0][FREQ_W-1:0] freq_sh;
    logic [NUM_CH-1:0]             en_v;
    logic [NUM_CH-1:0]             run_v;
    logic [NUM_CH-1:0]             wrap_v;
    logic [NUM_CH-1:0][DUTY_W-1:0] quant_v;
    logic [NUM_CH-1:0][DUTY_W-1:0] dact_v;
    logic [NUM_CH-1:0][FREQ_W-1:0] fact_v;
    logic [NUM_CH-1:0][PRE_W-1:0]  pre_v;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .rdata  (reg_rdata),
        .duty_o (duty_sh),
        .freq_o (freq_sh),
        .en_o   (en_v)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en_v[n]),
            .duty_sh_i  (duty_sh[n]),
            .freq_sh_i  (freq_sh[n]),
            .pwm_o      (pwm_o[n]),
            .run_o      (run_v[n]),
            .wrap_o     (wrap_v[n]),
            .quant_o    (quant_v[n]),
            .duty_act_o (dact_v[n]),
            .freq_act_o (fact_v[n]),
            .pre_o      (pre_v[n])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             en_v,
    input logic [NUM_CH-1:0]             pwm_v,
    input logic [NUM_CH-1:0]             run_v,
    input logic [NUM_CH-1:0]             wrap_v,
    input logic [NUM_CH-1:0][DUTY_W-1:0] quant_v,
    input logic [NUM_CH-1:0][DUTY_W-1:0] dact_v,
    input logic [NUM_CH-1:0][FREQ_W-1:0] fact_v,
    input logic [NUM_CH-1:0][PRE_W-1:0]  pre_v,
    input logic [NUM_CH-1:0][DUTY_W-1:0] duty_sh
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_v[n] |-> (en_v[n] && run_v[n])); // R8

        AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            run_v[n] |-> (pre_v[n] < (PRE_W'(RATIO_BASE) - PRE_W'(fact_v[n])))); // R4

        AST_QUANT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[n] && $past(run_v[n]) && !$stable(quant_v[n]))
                |-> (quant_v[n] == ($past(quant_v[n]) + DUTY_W'(1)))); // R5

        AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_v[n]) |-> ((quant_v[n] == '0) && (pre_v[n] == '0)
                                 && (dact_v[n] == $past(duty_sh[n])))); // R9

        AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[n] && $past(run_v[n]) && !$past(wrap_v[n]))
                |-> ($stable(dact_v[n]) && $stable(fact_v[n]))); // R10
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_v    (en_v),
    .pwm_v   (pwm_o),
    .run_v   (run_v),
    .wrap_v  (wrap_v),
    .quant_v (quant_v),
    .dact_v  (dact_v),
    .fact_v  (fact_v),
    .pre_v   (pre_v),
    .duty_sh (duty_sh)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;

    localparam int NCH = 4;
    localparam int AW  = 4;
    localparam int EN_A = 2 * NCH;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [AW-1:0]  addr;
    logic [7:0]     wdata;
    logic           we;
    logic [7:0]     rdata;
    logic [NCH-1:0] pwm;

    always #5 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_we    (we),
        .reg_rdata (rdata),
        .pwm_o     (pwm)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected level t cycles after the first high cycle of a fresh period
    function automatic bit exp_level(input int t, input int d, input int f);
        int p;
        int per;
        p   = 32 - f;
        per = 1024 * p;
        return (t % per) < ((d + 1) * p);
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr  = a[AW-1:0];
        wdata = d[7:0];
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = a[AW-1:0];
        #1;
        v = int'(rdata);
    endtask

    task automatic cfg(input int ch, input int d, input int f);
        wr(2 * ch, d & 8'hFF);
        wr(2 * ch + 1, ((f & 4'hF) << 4) | ((d >> 8) & 3));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        int d[NCH];
        int f[NCH];
        int err[NCH];
        int first[NCH];
        int wv[2 * NCH];
        int other;
        bit e;

        void'($urandom(32'd4711));
        rst_n = 1'b0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (4) @(negedge clk);
        chk(pwm == '0, "R1", "outputs in reset", int'(pwm), 0);
        rst_n = 1'b1;
        for (int a = 0; a <= EN_A; a++) begin
            rd(a, v);
            chk(v == 0, "R1", $sformatf("reset value addr %0d", a), v, 0);
        end

        // R2 / R3: random readback, reserved bits masked
        for (int a = 0; a < 2 * NCH; a++) begin
            wv[a] = int'($urandom_range(0, 255));
            wr(a, wv[a]);
        end
        for (int a = 0; a < 2 * NCH; a++) begin
            rd(a, v);
            if (a % 2 == 1)
                chk(v == (wv[a] & 8'hF3), "R3", $sformatf("reserved bits addr %0d", a), v, wv[a] & 8'hF3);
            else
                chk(v == wv[a], "R2", $sformatf("readback addr %0d", a), v, wv[a]);
        end
        wr(1, 8'hFF);
        rd(1, v);
        chk(v == 8'hF3, "R3", "reserved bits ignore 0xFF", v, 8'hF3);
        wr(EN_A, 8'hFF);
        rd(EN_A, v);
        chk(v == 8'h0F, "R3", "enable bits above channel count", v, 8'h0F);
        wr(EN_A, 8'h00);
        chk(pwm == '0, "R8", "all low after clearing enables", int'(pwm), 0);

        // Round A: all channels, fresh start, directed and random settings
        d[0] = 0;    f[0] = 15;
        d[1] = 1023; f[1] = 15;
        d[2] = int'($urandom_range(1, 1022)); f[2] = 14 + int'($urandom_range(0, 1));
        d[3] = int'($urandom_range(1, 1022)); f[3] = 14 + int'($urandom_range(0, 1));
        for (int c = 0; c < NCH; c++) cfg(c, d[c], f[c]);
        for (int c = 0; c < NCH; c++) begin err[c] = 0; first[c] = -1; end
        wr(EN_A, 8'h0F);
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < 36900; t++) begin
            for (int c = 0; c < NCH; c++) begin
                e = exp_level(t, d[c], f[c]);
                if (pwm[c] !== e) begin
                    if (err[c] == 0) first[c] = t;
                    err[c]++;
                end
            end
            @(negedge clk);
        end
        chk(err[0] == 0, "R6", "ch0 single-quantum pulse, first bad cycle", first[0], -1);
        chk(err[1] == 0, "R7", "ch1 full duty, first bad cycle", first[1], -1);
        chk(err[2] == 0, "R4", $sformatf("ch2 D=%0d F=%0d, first bad cycle", d[2], f[2]), first[2], -1);
        chk(err[3] == 0, "R5", $sformatf("ch3 D=%0d F=%0d, first bad cycle", d[3], f[3]), first[3], -1);

        // Round B: mid-period update of channel 2 only
        wr(EN_A, 8'h00);
        chk(pwm == '0, "R8", "low right after disable", int'(pwm), 0);
        cfg(2, 100, 15);
        wr(EN_A, 8'h04);
        err[2] = 0; first[2] = -1; other = 0;
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < 17408 + 18432 + 300; t++) begin
            if (t < 17408) e = exp_level(t, 100, 15);
            else           e = exp_level(t - 17408, 288, 14);
            if (pwm[2] !== e) begin
                if (err[2] == 0) first[2] = t;
                err[2]++;
            end
            if ((pwm & 4'b1011) != '0) other++;
            if (t == 3000) begin
                addr = 4'd4; wdata = 8'h20; we = 1'b1;
            end else if (t == 3001) begin
                addr = 4'd5; wdata = 8'hE1; we = 1'b1;
            end else if (t == 3002) begin
                we = 1'b0;
            end
            @(negedge clk);
        end
        chk(err[2] == 0, "R10", "shadow update at boundary, first bad cycle", first[2], -1);
        chk(other == 0, "R8", "disabled channels stay low, high cycles", other, 0);

        // Round C: re-enable with slowest code starts a fresh period
        wr(EN_A, 8'h00);
        cfg(2, 5, 0);
        wr(EN_A, 8'h04);
        err[2] = 0; first[2] = -1;
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < 33000; t++) begin
            e = exp_level(t, 5, 0);
            if (pwm[2] !== e) begin
                if (err[2] == 0) first[2] = t;
                err[2]++;
            end
            @(negedge clk);
        end
        chk(err[2] == 0, "R9", "fresh period at F=0, first bad cycle", first[2], -1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule